// File: doc/BRIEF.md
# Delayed Command Cluster Timer

This block sets when clusters of stored commands fall due. Time is counted in coarse units. One unit stands for eight seconds and arrives as a one-cycle `tick_i` pulse from an outside prescaler. Each cluster carries a delay of up to 14 bits, giving about 36 hours of range, and a command count of one to four. Command storage and execution sit outside the block. It only reports which cluster is due and how many commands that cluster holds.

The block has two countdown channels that work in turn. Successive clusters go to channel 0, then channel 1, then channel 0 again. Each channel holds one running cluster and one queued cluster. While one channel waits for its due cluster to be serviced, the other keeps counting, so the timing of the next cluster does not slip. No counting happens until an epoch strobe arrives. Acknowledging a due cluster reloads its channel from the queued cluster, and the new delay counts from the acknowledge.

Top module: `dly_cluster_timer`

## Requirements
- R1: Accepted loads go to the channels in turn, starting with channel 0 after reset. Each accepted load takes a sequence index that starts at 0 and goes up by one. Clusters are serviced in load order, and `svc_chan_o` / `svc_idx_o` name the current cluster.
- R2: Before `epoch_i` is seen, ticks do not count. No due flag rises and `busy_o` stays low.
- R3: A cluster with delay d >= 1 becomes due on the clock edge of the d-th tick after counting starts.
- R4: A cluster with delay 0 becomes due on the first tick.
- R5: A due flag stays set until `ack_i` is high while `svc_valid_o` is high. An acknowledge while `svc_valid_o` is low has no effect.
- R6: While one channel is due, the other channel keeps counting its own delay.
- R7: Acknowledging a due cluster reloads its channel from that channel's queued cluster. The queued delay counts from the acknowledge.
- R8: A load is rejected when its target channel already holds both a running cluster and a queued cluster. On the next cycle `err_o` pulses for one cycle, and no index or channel turn is used up.
- R9: `busy_o` is high while counting is enabled and any channel holds a cluster. It drops on the edge that acknowledges the last cluster.
- R10: `svc_ncmd_o` gives the command count of the current cluster minus one. This 2-bit field encodes 1 to 4 commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per time unit |
| epoch_i | input | 1 | Starts the countdown of loaded clusters |
| load_i | input | 1 | Load strobe for one cluster |
| load_dly_i | input | 14 | Cluster delay in time units |
| load_ncmd_i | input | 2 | Command count minus one |
| ack_i | input | 1 | Acknowledges the current due cluster |
| due_o | output | 2 | Due flag per channel |
| svc_valid_o | output | 1 | Current cluster is due |
| svc_chan_o | output | 1 | Channel of the current cluster |
| svc_idx_o | output | 3 | Sequence index of the current cluster |
| svc_ncmd_o | output | 2 | Command count minus one of the current cluster |
| busy_o | output | 1 | Delayed-command telltale |
| err_o | output | 1 | Rejected-load pulse |

## Verification
A table of single clusters is run one at a time. The delays include zero, one, short and longer values, and the command counts cover all four codes. This separates off-by-one errors in the countdown, the special handling of zero, and the alternation between channels. A directed ping-pong sequence fills both running slots and both queued slots, then forces one more load. This shows that a held due flag does not stall the other channel, that queued delays restart at the acknowledge, and that a rejected load uses up no index. A pre-epoch run and a stray acknowledge show that counting and service order are gated as required.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned NCH = 2;
  typedef enum logic [1:0] {CH_IDLE = 2'd0, CH_COUNT = 2'd1, CH_DUE = 2'd2} ch_state_e;
endpackage

// File: rtl/dct_chan.sv
module dct_chan
  import dct_pkg::*;
#(
  parameter int unsigned DLY_W  = 14,
  parameter int unsigned NCMD_W = 2,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [NCMD_W-1:0] ncmd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ack_i,
  output logic              due_o,
  output logic              armed_o,
  output logic              full_o,
  output logic [NCMD_W-1:0] ncmd_o,
  output logic [IDX_W-1:0]  idx_o
);
  ch_state_e         state_q;
  logic [DLY_W-1:0]  cnt_q, sh_dly_q;
  logic [NCMD_W-1:0] ncmd_q, sh_ncmd_q;
  logic [IDX_W-1:0]  idx_q, sh_idx_q;
  logic              sh_v_q;
  logic              ack_due;

  assign ack_due = ack_i && (state_q == CH_DUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CH_IDLE;
      cnt_q     <= '0;
      ncmd_q    <= '0;
      idx_q     <= '0;
      sh_dly_q  <= '0;
      sh_ncmd_q <= '0;
      sh_idx_q  <= '0;
      sh_v_q    <= 1'b0;
    end else if (ack_due) begin
      if (sh_v_q) begin
        // queued cluster moves up; its delay counts from here
        cnt_q   <= sh_dly_q;
        ncmd_q  <= sh_ncmd_q;
        idx_q   <= sh_idx_q;
        state_q <= CH_COUNT;
        sh_v_q  <= load_i;
        if (load_i) begin
          sh_dly_q  <= dly_i;
          sh_ncmd_q <= ncmd_i;
          sh_idx_q  <= idx_i;
        end
      end else if (load_i) begin
        cnt_q   <= dly_i;
        ncmd_q  <= ncmd_i;
        idx_q   <= idx_i;
        state_q <= CH_COUNT;
      end else begin
        state_q <= CH_IDLE;
      end
    end else begin
      if (load_i && state_q != CH_IDLE) begin
        sh_dly_q  <= dly_i;
        sh_ncmd_q <= ncmd_i;
        sh_idx_q  <= idx_i;
        sh_v_q    <= 1'b1;
      end
      if (load_i && state_q == CH_IDLE) begin
        cnt_q   <= dly_i;
        ncmd_q  <= ncmd_i;
        idx_q   <= idx_i;
        state_q <= CH_COUNT;
      end else if (tick_i && run_i && state_q == CH_COUNT) begin
        // zero and one both expire on this tick
        if (cnt_q <= DLY_W'(1)) state_q <= CH_DUE;
        else                    cnt_q   <= cnt_q - DLY_W'(1);
      end
    end
  end

  assign due_o   = (state_q == CH_DUE);
  assign armed_o = (state_q != CH_IDLE);
  assign full_o  = armed_o && sh_v_q;
  assign ncmd_o  = ncmd_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/dct_sched.sv
module dct_sched
  import dct_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             epoch_i,
  input  logic             ack_i,
  input  logic [NCH-1:0]   full_i,
  input  logic [NCH-1:0]   due_i,
  input  logic [NCH-1:0]   armed_i,
  output logic [NCH-1:0]   load_en_o,
  output logic [NCH-1:0]   ack_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             turn_o,
  output logic             run_o,
  output logic             busy_o,
  output logic             err_o
);
  logic             ptr_q, turn_q, run_q, err_q;
  logic [IDX_W-1:0] seq_q;
  logic             accept, ack_ok;

  assign accept = load_i && !full_i[ptr_q];
  assign ack_ok = ack_i && due_i[turn_q];

  always_comb begin
    load_en_o = '0;
    ack_en_o  = '0;
    load_en_o[ptr_q]  = accept;
    ack_en_o[turn_q]  = ack_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= 1'b0;
      turn_q <= 1'b0;
      run_q  <= 1'b0;
      err_q  <= 1'b0;
      seq_q  <= '0;
    end else begin
      if (accept) begin
        ptr_q <= ~ptr_q;
        seq_q <= seq_q + IDX_W'(1);
      end
      if (ack_ok) turn_q <= ~turn_q;
      run_q <= epoch_i || (run_q && (|armed_i));
      err_q <= load_i && full_i[ptr_q];
    end
  end

  assign idx_o  = seq_q;
  assign turn_o = turn_q;
  assign run_o  = run_q;
  assign busy_o = run_q && (|armed_i);
  assign err_o  = err_q;
endmodule

// File: rtl/dly_cluster_timer.sv
module dly_cluster_timer
  import dct_pkg::*;
#(
  parameter int unsigned DLY_W  = 14,
  parameter int unsigned NCMD_W = 2,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              epoch_i,
  input  logic              load_i,
  input  logic [DLY_W-1:0]  load_dly_i,
  input  logic [NCMD_W-1:0] load_ncmd_i,
  input  logic              ack_i,
  output logic [1:0]        due_o,
  output logic              svc_valid_o,
  output logic              svc_chan_o,
  output logic [IDX_W-1:0]  svc_idx_o,
  output logic [NCMD_W-1:0] svc_ncmd_o,
  output logic              busy_o,
  output logic              err_o
);
  logic [NCH-1:0]    load_en, ack_en, full, due, armed;
  logic [IDX_W-1:0]  next_idx;
  logic              turn, run;
  logic [NCMD_W-1:0] ch_ncmd [NCH];
  logic [IDX_W-1:0]  ch_idx  [NCH];

  dct_sched #(.IDX_W(IDX_W)) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .epoch_i   (epoch_i),
    .ack_i     (ack_i),
    .full_i    (full),
    .due_i     (due),
    .armed_i   (armed),
    .load_en_o (load_en),
    .ack_en_o  (ack_en),
    .idx_o     (next_idx),
    .turn_o    (turn),
    .run_o     (run),
    .busy_o    (busy_o),
    .err_o     (err_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dct_chan #(.DLY_W(DLY_W), .NCMD_W(NCMD_W), .IDX_W(IDX_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .run_i   (run),
      .load_i  (load_en[g]),
      .dly_i   (load_dly_i),
      .ncmd_i  (load_ncmd_i),
      .idx_i   (next_idx),
      .ack_i   (ack_en[g]),
      .due_o   (due[g]),
      .armed_o (armed[g]),
      .full_o  (full[g]),
      .ncmd_o  (ch_ncmd[g]),
      .idx_o   (ch_idx[g])
    );
  end

  assign due_o       = due;
  assign svc_chan_o  = turn;
  assign svc_valid_o = due[turn];
  assign svc_idx_o   = ch_idx[turn];
  assign svc_ncmd_o  = ch_ncmd[turn];
endmodule

// File: rtl/dct_checker.sv
module dct_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       epoch_i,
  input logic       load_i,
  input logic       ack_i,
  input logic [1:0] due_o,
  input logic       svc_valid_o,
  input logic       svc_chan_o,
  input logic       busy_o,
  input logic       err_o
);
  p_due_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due_o[0] && !(ack_i && svc_valid_o && !svc_chan_o)) |=> due_o[0]);

  p_due_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !due_o[1]) |=> !due_o[1]);

  p_no_count_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !epoch_i) |=> ((due_o & ~$past(due_o)) == 2'b00));

  p_err_after_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(load_i));

  p_turn_on_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && svc_valid_o) |=> $stable(svc_chan_o));
endmodule

bind dly_cluster_timer dct_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .epoch_i     (epoch_i),
  .load_i      (load_i),
  .ack_i       (ack_i),
  .due_o       (due_o),
  .svc_valid_o (svc_valid_o),
  .svc_chan_o  (svc_chan_o),
  .busy_o      (busy_o),
  .err_o       (err_o)
);

// File: tb/sim_dly_cluster_timer.sv
module sim_dly_cluster_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, epoch_i = 1'b0, load_i = 1'b0, ack_i = 1'b0;
  logic [13:0] load_dly_i = '0;
  logic [1:0]  load_ncmd_i = '0;
  logic [1:0]  due_o;
  logic        svc_valid_o, svc_chan_o, busy_o, err_o;
  logic [2:0]  svc_idx_o;
  logic [1:0]  svc_ncmd_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  localparam int NV = 6;
  localparam int VD [NV] = '{0, 1, 2, 5, 3, 7};
  localparam int VN [NV] = '{0, 1, 2, 3, 1, 2};

  always #2 clk = ~clk;

  dly_cluster_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .epoch_i(epoch_i),
    .load_i(load_i), .load_dly_i(load_dly_i), .load_ncmd_i(load_ncmd_i),
    .ack_i(ack_i), .due_o(due_o), .svc_valid_o(svc_valid_o),
    .svc_chan_o(svc_chan_o), .svc_idx_o(svc_idx_o), .svc_ncmd_o(svc_ncmd_o),
    .busy_o(busy_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_load(input int d, input int n);
    load_i = 1'b1; load_dly_i = 14'(d); load_ncmd_i = 2'(n);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_epoch();
    epoch_i = 1'b1; @(negedge clk); epoch_i = 1'b0;
  endtask

  task automatic do_tick();
    tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    eq("R9 reset busy", busy_o, 0);
    eq("R5 reset due", due_o, 0);
    eq("R8 reset err", err_o, 0);
    eq("R1 reset chan", svc_chan_o, 0);

    // vector table: single clusters, one after another
    for (int i = 0; i < NV; i++) begin
      int eff;
      eff = (VD[i] == 0) ? 1 : VD[i];
      do_load(VD[i], VN[i]);
      do_epoch();
      for (int k = 1; k < eff; k++) begin
        do_tick();
        eq("R3 early due", svc_valid_o, 0);
      end
      do_tick();
      if (VD[i] == 0) eq("R4 zero delay due", svc_valid_o, 1);
      else            eq("R3 due at d-th tick", svc_valid_o, 1);
      eq("R1 chan", svc_chan_o, i % 2);
      eq("R1 idx", svc_idx_o, i);
      eq("R10 ncmd", svc_ncmd_o, VN[i]);
      eq("R9 busy while held", busy_o, 1);
      do_ack();
      eq("R9 busy after last ack", busy_o, 0);
      eq("R5 cleared by ack", due_o, 0);
    end

    // R2: no counting before epoch
    do_reset();
    do_load(1, 0);
    do_tick(); do_tick(); do_tick();
    eq("R2 no due before epoch", due_o, 0);
    eq("R2 busy low before epoch", busy_o, 0);
    do_epoch();
    do_tick();
    eq("R3 due after epoch", due_o, 1);

    // R5: stray ack ignored
    do_reset();
    do_load(2, 0);
    do_epoch();
    do_ack();
    eq("R5 stray ack chan", svc_chan_o, 0);
    do_tick(); do_tick();
    eq("R5 stray ack due", svc_valid_o, 1);
    eq("R5 stray ack idx", svc_idx_o, 0);

    // ping-pong with queued clusters
    do_reset();
    do_load(2, 0);   // A ch0 idx0
    do_load(4, 1);   // B ch1 idx1
    do_load(3, 2);   // C ch0 queued idx2
    do_load(1, 3);   // D ch1 queued idx3
    eq("R8 no err on queue", err_o, 0);
    do_load(5, 0);   // E rejected
    eq("R8 err pulse", err_o, 1);
    @(negedge clk);
    eq("R8 err one cycle", err_o, 0);
    do_epoch();
    do_tick(); do_tick();
    eq("R3 A due", due_o, 1);
    eq("R1 A idx", svc_idx_o, 0);
    do_tick(); do_tick();
    eq("R6 B due while A held", due_o, 3);
    eq("R5 A still current", svc_idx_o, 0);
    do_ack();
    eq("R1 B now current", svc_chan_o, 1);
    eq("R1 B idx", svc_idx_o, 1);
    eq("R10 B ncmd", svc_ncmd_o, 1);
    eq("R7 ch0 reloaded not due", due_o[0], 0);
    do_ack();
    eq("R7 ch0 waits", svc_valid_o, 0);
    do_tick();
    eq("R7 D due after one tick", due_o, 2);
    do_tick();
    eq("R7 C not yet due", due_o[0], 0);
    do_tick();
    eq("R7 C due third tick", svc_valid_o, 1);
    eq("R8 C idx unconsumed", svc_idx_o, 2);
    eq("R10 C ncmd", svc_ncmd_o, 2);
    do_ack();
    eq("R1 D current", svc_chan_o, 1);
    eq("R1 D idx", svc_idx_o, 3);
    eq("R9 busy mid", busy_o, 1);
    do_ack();
    eq("R9 busy drops", busy_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule